// File: doc/BRIEF.md
# Region Cache Maintenance Engine

This block carries out maintenance work on a second-level cache. It can write back dirty lines (flush), drop lines without writing them back (invalidate), or do both in one pass (flush-and-invalidate). Software sets the control register first. It then writes the region end address, and then the region start address. The start write launches the pass. The engine walks the physical line addresses from the start line up to the end line. At each line it consults a small tag/valid/dirty model of the cache and raises a write-back request for every dirty line the operation must push out. The busy flag in the control register stays high until the last line has been handled.

Two extra command registers start a pass over every entry of the store, with no address range. The cache arrays are modelled by a direct-mapped store of `SETS` entries. A fill port installs lines into it. A probe port reports whether an address is resident and dirty. Line size is 128 bytes or 64 bytes, picked by a configuration input.

Top module: `rcm_engine`

## Requirements
- R1: After reset the control register reads zero, `busy` and `wb_valid` are low, and every probe reports a miss.
- R2: Register select 0 is the control register. In it, bit 0 is a disable flag, bit 6 is the invalidate mode, bits 11:9 are the region operation code and bit 8 is busy. Written fields read back unchanged. Bit 8 is read-only and reflects `busy`.
- R3: Select 1 holds the region end and select 2 the region start. A write to select 2 while idle launches a region pass. The control register read in the cycle after that write already shows busy. A write to the end register alone starts nothing.
- R4: Operation code 000 is flush. Each resident dirty line in the range is written back, then stays resident and becomes clean. Clean lines are left as they are.
- R5: Code 001 with mode 0 is invalidate. Resident lines in the range are dropped, and no write-back is issued even for dirty lines.
- R6: Code 001 with mode 1 is flush-and-invalidate. Each dirty line in the range is written back, and every resident line in the range is then dropped.
- R7: Address bits below the line size are ignored in both start and end. The pass covers the start line through the end line inclusive, in ascending address order. If the end line is below the start line, only the start line is handled. Lines outside the range are not touched.
- R8: Line size is 128 bytes when `line_cfg` is 0 and 64 bytes when it is 1. Write-back addresses are line aligned.
- R9: A write-back request holds `wb_valid` and a stable `wb_addr` until `wb_ack`. `busy` stays high until the last line, including its write-back, completes.
- R10: A write to select 5 runs invalidate (mode 0) or flush-and-invalidate (mode 1) over all resident entries. A write to select 6 flushes all entries. Entries are visited in ascending set order.
- R11: While busy, every register write and every fill is ignored.
- R12: Selects 3 and 4 are the upper address extension registers. With wide addressing not configured (default), they read zero and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for writes |
| reg_wdata | input | AW | Register write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | AW | Read data for `rd_sel` |
| line_cfg | input | 1 | Line size select: 0 gives 128 bytes, 1 gives 64 bytes |
| fill_en | input | 1 | Install a line into the tag model |
| fill_addr | input | AW | Address of the installed line |
| fill_dirty | input | 1 | Installed line is dirty |
| probe_addr | input | AW | Address to look up |
| probe_hit | output | 1 | Probe address is resident |
| probe_dirty | output | 1 | Probe address is resident and dirty |
| wb_valid | output | 1 | Write-back request pending |
| wb_addr | output | AW | Line-aligned write-back address |
| wb_ack | input | 1 | Write-back accepted |
| busy | output | 1 | Maintenance pass in progress |

## Verification
The assertions assume three things about the inputs. `line_cfg` stays fixed while lines are resident in the model. `wb_ack` is raised only while `wb_valid` is high. Registers are programmed with the control value before end and start. The stimulus meets the first assumption by changing `line_cfg` only after an entire flush-and-invalidate has emptied the store. It meets the second by having the acknowledging monitor answer only requests it has seen. It meets the third because the driver tasks always write control, then end, then start. Ack latency varies from zero to many cycles, so both the single-cycle line step and the write-back wait are covered.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  typedef enum logic [1:0] {
    OP_FLUSH = 2'd0,
    OP_INV   = 2'd1,
    OP_FINV  = 2'd2
  } mop_e;

  localparam logic [2:0] SEL_CTRL      = 3'd0;
  localparam logic [2:0] SEL_END       = 3'd1;
  localparam logic [2:0] SEL_START     = 3'd2;
  localparam logic [2:0] SEL_END_HI    = 3'd3;
  localparam logic [2:0] SEL_START_HI  = 3'd4;
  localparam logic [2:0] SEL_ALL_INV   = 3'd5;
  localparam logic [2:0] SEL_ALL_FLUSH = 3'd6;

  localparam int unsigned CB_DIS   = 0;
  localparam int unsigned CB_MODE  = 6;
  localparam int unsigned CB_BUSY  = 8;
  localparam int unsigned CB_OP_LO = 9;

  // region code 001 selects the invalidate class; every other code flushes
  function automatic mop_e decode_region(input logic [2:0] code, input logic inv_mode);
    mop_e r;
    r = OP_FLUSH;
    if (code == 3'b001) r = inv_mode ? OP_FINV : OP_INV;
    return r;
  endfunction

  function automatic mop_e decode_whole(input logic inv_reg, input logic inv_mode);
    mop_e r;
    r = OP_FLUSH;
    if (inv_reg) r = inv_mode ? OP_FINV : OP_INV;
    return r;
  endfunction

endpackage

// File: rtl/rcm_regs.sv
module rcm_regs
  import rcm_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter bit          HI_EN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic [2:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          busy,
  output logic          inv_mode,
  output logic [2:0]    rgn_code,
  output logic [AW-1:0] end_addr,
  output logic          launch_rgn,
  output logic          launch_all,
  output logic          all_is_inv
);

  logic          dis_q, mode_q;
  logic [2:0]    code_q;
  logic [AW-1:0] end_q, start_q;
  logic [AW-1:0] end_hi, start_hi;
  logic          wr_ok;

  assign wr_ok = we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      mode_q  <= 1'b0;
      code_q  <= 3'd0;
      end_q   <= '0;
      start_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_CTRL: begin
          dis_q  <= wdata[CB_DIS];
          mode_q <= wdata[CB_MODE];
          code_q <= wdata[CB_OP_LO +: 3];
        end
        SEL_END:   end_q   <= wdata;
        SEL_START: start_q <= wdata;
        default: ;
      endcase
    end
  end

  generate
    if (HI_EN) begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          end_hi   <= '0;
          start_hi <= '0;
        end else if (wr_ok) begin
          if (sel == SEL_END_HI)   end_hi   <= wdata;
          if (sel == SEL_START_HI) start_hi <= wdata;
        end
      end
    end else begin : g_nohi
      assign end_hi   = '0;
      assign start_hi = '0;
    end
  endgenerate

  assign launch_rgn = wr_ok && (sel == SEL_START);
  assign launch_all = wr_ok && ((sel == SEL_ALL_INV) || (sel == SEL_ALL_FLUSH));
  assign all_is_inv = (sel == SEL_ALL_INV);
  assign inv_mode   = mode_q;
  assign rgn_code   = code_q;
  assign end_addr   = end_q;

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL: begin
        rd_data[CB_DIS]       = dis_q;
        rd_data[CB_MODE]      = mode_q;
        rd_data[CB_BUSY]      = busy;
        rd_data[CB_OP_LO +: 3] = code_q;
      end
      SEL_END:      rd_data = end_q;
      SEL_START:    rd_data = start_q;
      SEL_END_HI:   rd_data = end_hi;
      SEL_START_HI: rd_data = start_hi;
      default:      rd_data = '0;
    endcase
  end

  // R11: programming is frozen during a pass
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(end_q) && $stable(start_q) && $stable(code_q) && $stable(mode_q)));

endmodule

// File: rtl/rcm_tagstore.sv
module rcm_tagstore #(
  parameter int unsigned LW   = 26,
  parameter int unsigned SETS = 8,
  localparam int unsigned IDXW = $clog2(SETS),
  localparam int unsigned TW   = LW - IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_en,
  input  logic [LW-1:0]   fill_line,
  input  logic            fill_dirty,
  input  logic [LW-1:0]   a_line,
  input  logic            a_whole,
  output logic            a_hit,
  output logic            a_dirty,
  output logic [LW-1:0]   a_stored,
  input  logic            u_en,
  input  logic [IDXW-1:0] u_idx,
  input  logic            u_kill,
  input  logic            u_clean,
  input  logic [LW-1:0]   p_line,
  output logic            p_hit,
  output logic            p_dirty
);

  logic [SETS-1:0] vld, drt;
  logic [TW-1:0]   tg [SETS];

  logic [IDXW-1:0] a_idx, p_idx, f_idx;
  assign a_idx = a_line[IDXW-1:0];
  assign p_idx = p_line[IDXW-1:0];
  assign f_idx = fill_line[IDXW-1:0];

  assign a_hit    = vld[a_idx] && (a_whole || (tg[a_idx] == a_line[LW-1:IDXW]));
  assign a_dirty  = drt[a_idx];
  assign a_stored = {tg[a_idx], a_idx};

  assign p_hit   = vld[p_idx] && (tg[p_idx] == p_line[LW-1:IDXW]);
  assign p_dirty = p_hit && drt[p_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      drt <= '0;
      for (int i = 0; i < SETS; i++) tg[i] <= '0;
    end else begin
      if (u_en) begin
        if (u_kill) begin
          vld[u_idx] <= 1'b0;
          drt[u_idx] <= 1'b0;
        end else if (u_clean) begin
          drt[u_idx] <= 1'b0;
        end
      end
      if (fill_en) begin
        vld[f_idx] <= 1'b1;
        drt[f_idx] <= fill_dirty;
        tg[f_idx]  <= fill_line[LW-1:IDXW];
      end
    end
  end

  // R5/R6: a drop leaves the set empty
  p_kill_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (u_en && u_kill && !fill_en) |=> !vld[$past(u_idx)]);

endmodule

// File: rtl/rcm_walker.sv
module rcm_walker
  import rcm_pkg::*;
#(
  parameter int unsigned LW   = 26,
  parameter int unsigned SETS = 8,
  localparam int unsigned IDXW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch_rgn,
  input  logic            launch_all,
  input  mop_e            op_in,
  input  logic [LW-1:0]   first_line,
  input  logic [LW-1:0]   last_line,
  output logic [LW-1:0]   lk_line,
  output logic            lk_whole,
  input  logic            lk_hit,
  input  logic            lk_dirty,
  input  logic [LW-1:0]   lk_stored,
  input  logic            wb_ack,
  output logic            wb_valid,
  output logic [LW-1:0]   wb_line,
  output logic            u_en,
  output logic [IDXW-1:0] u_idx,
  output logic            u_kill,
  output logic            u_clean,
  output logic            busy
);

  typedef enum logic [1:0] {W_IDLE, W_LOOK, W_WAIT} wst_e;

  wst_e          st_q;
  logic [LW-1:0] cur_q, last_q, wbl_q;
  mop_e          op_q;
  logic          whole_q;

  logic need_wb, at_end, adv;

  assign need_wb = lk_hit && lk_dirty && (op_q != OP_INV);
  assign at_end  = (cur_q >= last_q);
  assign lk_line = cur_q;
  assign lk_whole = whole_q;
  assign u_idx   = cur_q[IDXW-1:0];
  assign busy    = (st_q != W_IDLE);
  assign wb_valid = (st_q == W_WAIT);
  assign wb_line = wbl_q;

  always_comb begin
    adv = 1'b0; u_en = 1'b0; u_kill = 1'b0; u_clean = 1'b0;
    if (st_q == W_LOOK && !need_wb) begin
      adv = 1'b1;
      if (lk_hit && op_q != OP_FLUSH) begin
        u_en = 1'b1; u_kill = 1'b1;
      end
    end else if (st_q == W_WAIT && wb_ack) begin
      adv = 1'b1; u_en = 1'b1;
      u_kill  = (op_q != OP_FLUSH);
      u_clean = (op_q == OP_FLUSH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; cur_q <= '0; last_q <= '0; wbl_q <= '0;
      op_q <= OP_FLUSH; whole_q <= 1'b0;
    end else begin
      case (st_q)
        W_IDLE: begin
          if (launch_rgn) begin
            cur_q <= first_line; last_q <= last_line;
            whole_q <= 1'b0; op_q <= op_in; st_q <= W_LOOK;
          end else if (launch_all) begin
            cur_q <= '0; last_q <= LW'(SETS - 1);
            whole_q <= 1'b1; op_q <= op_in; st_q <= W_LOOK;
          end
        end
        W_LOOK: if (need_wb) begin
          wbl_q <= whole_q ? lk_stored : cur_q;
          st_q  <= W_WAIT;
        end
        default: ;
      endcase
      if (adv) begin
        if (at_end) st_q <= W_IDLE;
        else begin
          cur_q <= cur_q + 1'b1;
          st_q  <= W_LOOK;
        end
      end
    end
  end

  // R9: request held steady until accepted
  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_line)));
  // R5: plain invalidate never writes back
  p_no_wb_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_INV) |-> !wb_valid);
  // R7: lines visited one at a time, ascending
  p_step_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !at_end) |=> (cur_q == $past(cur_q) + 1'b1));

endmodule

// File: rtl/rcm_engine.sv
module rcm_engine
  import rcm_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned SETS  = 8,
  parameter bit          HI_EN = 1'b0,
  localparam int unsigned LW   = AW - 6,
  localparam int unsigned IDXW = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic [2:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          line_cfg,
  input  logic          fill_en,
  input  logic [AW-1:0] fill_addr,
  input  logic          fill_dirty,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit,
  output logic          probe_dirty,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  input  logic          wb_ack,
  output logic          busy
);

  // line number: address with the in-line offset removed
  function automatic logic [LW-1:0] to_line(input logic [AW-1:0] a, input logic cfg);
    logic [AW-1:0] s;
    s = cfg ? (a >> 6) : (a >> 7);
    return s[LW-1:0];
  endfunction

  function automatic logic [AW-1:0] to_addr(input logic [LW-1:0] l, input logic cfg);
    logic [AW-1:0] e;
    e = {l, 6'b0};
    return cfg ? e : (e << 1);
  endfunction

  logic          inv_mode, launch_rgn, launch_all, all_is_inv;
  logic [2:0]    rgn_code;
  logic [AW-1:0] end_addr;
  mop_e          op_sel;

  logic [LW-1:0]   lk_line, lk_stored, wb_line;
  logic            lk_whole, lk_hit, lk_dirty;
  logic            u_en, u_kill, u_clean;
  logic [IDXW-1:0] u_idx;

  rcm_regs #(.AW(AW), .HI_EN(HI_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .inv_mode(inv_mode),
    .rgn_code(rgn_code), .end_addr(end_addr), .launch_rgn(launch_rgn),
    .launch_all(launch_all), .all_is_inv(all_is_inv)
  );

  assign op_sel = launch_rgn ? decode_region(rgn_code, inv_mode)
                             : decode_whole(all_is_inv, inv_mode);

  rcm_walker #(.LW(LW), .SETS(SETS)) u_walk (
    .clk(clk), .rst_n(rst_n), .launch_rgn(launch_rgn), .launch_all(launch_all),
    .op_in(op_sel), .first_line(to_line(reg_wdata, line_cfg)),
    .last_line(to_line(end_addr, line_cfg)), .lk_line(lk_line), .lk_whole(lk_whole),
    .lk_hit(lk_hit), .lk_dirty(lk_dirty), .lk_stored(lk_stored), .wb_ack(wb_ack),
    .wb_valid(wb_valid), .wb_line(wb_line), .u_en(u_en), .u_idx(u_idx),
    .u_kill(u_kill), .u_clean(u_clean), .busy(busy)
  );

  rcm_tagstore #(.LW(LW), .SETS(SETS)) u_tags (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en && !busy),
    .fill_line(to_line(fill_addr, line_cfg)), .fill_dirty(fill_dirty),
    .a_line(lk_line), .a_whole(lk_whole), .a_hit(lk_hit), .a_dirty(lk_dirty),
    .a_stored(lk_stored), .u_en(u_en), .u_idx(u_idx), .u_kill(u_kill),
    .u_clean(u_clean), .p_line(to_line(probe_addr, line_cfg)),
    .p_hit(probe_hit), .p_dirty(probe_dirty)
  );

  assign wb_addr = to_addr(wb_line, line_cfg);

  // R3: start write while idle is visible as busy on the next cycle
  p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_START && !busy) |=> busy);
  // R8: write-back addresses are line aligned for the selected size
  p_wb_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((wb_addr[5:0] == 6'd0) && (line_cfg || !wb_addr[6])));
  // R12: upper extension registers read zero without wide addressing
  p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!HI_EN && (rd_sel == SEL_END_HI || rd_sel == SEL_START_HI)) |-> (rd_data == '0));

endmodule

// File: tb/sim_rcm_engine.sv
module sim_rcm_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  rd_sel = 3'd0;
  logic [31:0] rd_data;
  logic        line_cfg = 1'b0;
  logic        fill_en = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        fill_dirty = 1'b0;
  logic [31:0] probe_addr = '0;
  logic        probe_hit, probe_dirty, wb_valid, busy;
  logic [31:0] wb_addr;
  logic        wb_ack = 1'b0;

  always #10 clk = ~clk;

  rcm_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .line_cfg(line_cfg), .fill_en(fill_en),
    .fill_addr(fill_addr), .fill_dirty(fill_dirty), .probe_addr(probe_addr),
    .probe_hit(probe_hit), .probe_dirty(probe_dirty), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_ack(wb_ack), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ack_dly = 0;
  int sh = 7;

  // bench model of the cache: one line per set
  logic        m_v [8];
  logic        m_d [8];
  int unsigned m_line [8];
  logic [31:0] exq [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fill(input logic [31:0] a, input logic dty);
    int unsigned ln;
    fill_addr = a; fill_dirty = dty; fill_en = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
    ln = a >> sh;
    m_v[ln % 8] = 1'b1; m_d[ln % 8] = dty; m_line[ln % 8] = ln;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic eh, input logic ed);
    probe_addr = a;
    #1;
    chk(req, {30'd0, probe_hit, probe_dirty}, {30'd0, eh, ed});
  endtask

  // op: 0 flush, 1 invalidate, 2 flush-and-invalidate
  task automatic m_line_op(input int unsigned ln, input int op);
    int unsigned s;
    s = ln % 8;
    if (m_v[s] && m_line[s] == ln) begin
      if (op != 1 && m_d[s]) exq.push_back(ln << sh);
      if (op == 0) m_d[s] = 1'b0;
      else begin m_v[s] = 1'b0; m_d[s] = 1'b0; end
    end
  endtask

  task automatic wait_done(input string req);
    while (busy) @(negedge clk);
    chk(req, exq.size(), 0);
  endtask

  task automatic region(input string req, input logic [2:0] code, input logic mode,
                        input logic [31:0] st, input logic [31:0] en);
    int unsigned ls, le;
    int op;
    op = (code == 3'b001) ? (mode ? 2 : 1) : 0;
    ls = st >> sh; le = en >> sh;
    if (le < ls) le = ls;
    for (int unsigned l = ls; l <= le; l++) m_line_op(l, op);
    wr(3'd0, {20'd0, code, 2'b00, mode, 6'd0});
    wr(3'd1, en);
    chk("R3 idle before start", {31'd0, busy}, 32'd0);
    wr(3'd2, st);
    chk("R3 busy read after start", {31'd0, rd_data[8]}, 32'd1);
    wait_done(req);
  endtask

  task automatic whole(input string req, input logic inv, input logic mode);
    int op;
    op = inv ? (mode ? 2 : 1) : 0;
    for (int s = 0; s < 8; s++) if (m_v[s]) m_line_op(m_line[s], op);
    wr(3'd0, {25'd0, mode, 6'd0});
    wr(inv ? 3'd5 : 3'd6, 32'h1);
    wait_done(req);
  endtask

  // monitor: compare each write-back against the scoreboard, then accept it
  initial begin
    forever begin
      @(negedge clk);
      if (wb_valid) begin
        if (exq.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4/R6 unexpected write-back actual=%h expected=none", wb_addr);
        end else begin
          logic [31:0] e;
          e = exq.pop_front();
          chk("R4/R6/R7 write-back address", wb_addr, e);
          repeat (ack_dly) @(negedge clk);
          chk("R9 address held until ack", wb_addr, e);
          chk("R9 request held until ack", {31'd0, wb_valid}, 32'd1);
        end
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++) begin m_v[s] = 0; m_d[s] = 0; m_line[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ctrl reads zero", rd_data, 32'd0);
    chk("R1 idle", {30'd0, busy, wb_valid}, 32'd0);
    probe("R1 store empty", 32'h0, 1'b0, 1'b0);

    // R2 field readback, busy bit read-only
    wr(3'd0, 32'h0000_0341);
    chk("R2 ctrl fields", rd_data, 32'h0000_0241);
    wr(3'd0, 32'h0);

    // R4 flush with 128-byte lines (R8), ascending order (R7)
    fill(32'h1000, 1'b1); fill(32'h1080, 1'b0); fill(32'h1100, 1'b1); fill(32'h1180, 1'b1);
    ack_dly = 2;
    region("R4 flush range", 3'b000, 1'b0, 32'h1010, 32'h1120);
    probe("R4 flushed line stays clean", 32'h1000, 1'b1, 1'b0);
    probe("R4 clean line untouched", 32'h1080, 1'b1, 1'b0);
    probe("R7 line outside range untouched", 32'h1180, 1'b1, 1'b1);

    // R3 end write alone starts nothing
    wr(3'd1, 32'h1180);
    chk("R3 end write no launch", {30'd0, busy, wb_valid}, 32'd0);

    // R5 invalidate discards dirty data
    fill(32'h1000, 1'b1);
    region("R5 invalidate", 3'b001, 1'b0, 32'h1000, 32'h107F);
    probe("R5 line dropped", 32'h1000, 1'b0, 1'b0);
    probe("R5 neighbour kept", 32'h1080, 1'b1, 1'b0);

    // R6 flush-and-invalidate
    ack_dly = 0;
    region("R6 flush and invalidate", 3'b001, 1'b1, 32'h1080, 32'h11FF);
    probe("R6 clean line dropped", 32'h1080, 1'b0, 1'b0);
    probe("R6 dirty line dropped", 32'h1180, 1'b0, 1'b0);

    // R7 end below start handles only the start line
    fill(32'h2000, 1'b1); fill(32'h2080, 1'b1);
    region("R7 reversed range", 3'b000, 1'b0, 32'h2080, 32'h2000);
    probe("R7 lower line untouched", 32'h2000, 1'b1, 1'b1);

    // R10 entire-store passes
    whole("R10 whole flush-and-invalidate", 1'b1, 1'b1);
    probe("R10 whole drop", 32'h2000, 1'b0, 1'b0);
    fill(32'h3000, 1'b1); fill(32'h3380, 1'b1);
    whole("R10 whole invalidate", 1'b1, 1'b0);
    probe("R10 whole invalidate drops", 32'h3380, 1'b0, 1'b0);
    fill(32'h3000, 1'b1); fill(32'h3200, 1'b0); fill(32'h3380, 1'b1);
    ack_dly = 1;
    whole("R10 whole flush ascending", 1'b0, 1'b0);
    probe("R10 whole flush keeps line", 32'h3380, 1'b1, 1'b0);
    whole("R10 whole clear", 1'b1, 1'b1);

    // R8 64-byte lines
    line_cfg = 1'b1; sh = 6;
    fill(32'h3000, 1'b1); fill(32'h3040, 1'b1);
    region("R8 64-byte line range", 3'b000, 1'b0, 32'h3040, 32'h307F);
    probe("R8 other half untouched", 32'h3000, 1'b1, 1'b1);
    probe("R8 target line cleaned", 32'h3040, 1'b1, 1'b0);

    // R11 writes and fills ignored while busy
    fill(32'h4000, 1'b1); fill(32'h4040, 1'b1); fill(32'h4080, 1'b1);
    for (int unsigned l = 32'h4000 >> 6; l <= (32'h40BF >> 6); l++) m_line_op(l, 0);
    ack_dly = 10;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h40BF);
    wr(3'd2, 32'h4000);
    wr(3'd1, 32'hDEAD_0000);
    wr(3'd0, 32'h0000_0241);
    fill_addr = 32'h40C0; fill_dirty = 1'b1; fill_en = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
    chk("R11 still busy during writes", {31'd0, busy}, 32'd1);
    wait_done("R11 pass completes");
    chk("R11 ctrl unchanged", rd_data, 32'd0);
    rd_sel = 3'd1; #1;
    chk("R11 end unchanged", rd_data, 32'h0000_40BF);
    probe("R11 fill ignored", 32'h40C0, 1'b0, 1'b0);

    // R12 upper extension registers
    wr(3'd3, 32'h1234_5678);
    rd_sel = 3'd3; #1;
    chk("R12 upper end reads zero", rd_data, 32'd0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd_sel = 3'd4; #1;
    chk("R12 upper start reads zero", rd_data, 32'd0);
    rd_sel = 3'd0;

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule